// File: doc/BRIEF.md
# Sticky Interrupt Status Collector with Mask and Global Enable

This block gathers the sixteen event lines of a storage-card host controller into one raw status word. Each event sets its own status bit, and that bit stays set until software writes a 1 to its position. A per-bit mask and one global enable bit decide which of the set bits may drive the single interrupt line. The line is active-high and level-sensitive. It stays high for as long as any enabled bit remains set.

Fourteen of the sources are one-cycle pulses, and their status bits latch each pulse. The receive and transmit FIFO data requests are levels. While either request is still asserted, its bit sets again on the next clock edge, so software has to remove the cause before a clear will last.

Software reaches the block through a simple register port. The port has a write strobe, a two-bit word select shared by writes and reads, a 32-bit write word and a combinational read word. The port exposes four words: control, mask, raw status and masked status.

Top module: `irq_agg`

## Requirements
- R1: After reset the enable bit, every mask bit and every status bit are 0, `irq_o` is 0, and all four words read as 0.
- R2: A source input that is high at a clock edge sets its status bit at that edge. Bit k belongs to source k: 0 response error, 1 command done, 2 data transfer over, 3 transmit FIFO request, 4 receive FIFO request, 5 response CRC error, 6 data CRC error, 7 response timeout, 8 data read timeout, 9 host starvation timeout, 10 FIFO underflow/overflow, 11 hardware-locked write error, 12 start-bit error, 13 auto-command done, 14 missing CRC on write, 15 end-bit error.
- R3: A write to word 2 (raw status) clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: When a source is high at the same edge as a write-1 clear of its bit, the bit ends up set.
- R5: A clear of bit 3 or bit 4 has no lasting effect while that level source is still high. Once the source is low, the clear takes effect.
- R6: `irq_o` is 1 exactly when the enable bit is 1 and at least one status bit is 1 with its mask bit also 1. It follows register state in the same cycle.
- R7: A read of word 2 returns the unmasked status in bits 15:0, with bits 31:16 reading 0.
- R8: A read of word 3 returns the status ANDed with the mask in bits 15:0, with the upper bits reading 0.
- R9: Word 1 (mask) is read/write on bits 15:0. Word 0 (control) holds only the enable bit at bit 0. All other bits of both words read 0.
- R10: A write to word 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Event inputs, one per status bit |
| wr_en_i | input | 1 | Write strobe for the selected word |
| addr_i | input | 2 | Word select: 0 control, 1 mask, 2 raw status, 3 masked status |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data of the selected word, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The directed part runs through a fixed series of cases:
- a lone pulse, to show that the latch works while the mask is still 0;
- writes of 0 and of 1 to the raw word, to separate "unchanged" from "cleared";
- a clear that collides with a pulse on the same bit, to expose the set-versus-clear priority;
- a held level source, to show that a clear does not last while the request persists, and does once it has gone;
- every source at once, to check the full bit mapping and the zero upper half;
- writes of all ones to control, mask and the masked-status word, which expose bits that are not backed by storage and writes that are ignored.

A random phase then mixes sparse pulses, long-held FIFO requests and random writes to every word. A reference model checks `irq_o` and the selected read word on every cycle, so that mask/enable gating can be told apart from raw latching.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NUM_SRC = 16;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned EN_BIT  = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_MASK  = 2'd1,
    REG_RAW   = 2'd2,
    REG_MSTAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_stat_bit.sv
module irq_stat_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic clr_i,
  output logic stat_o
);
  // set dominates clear so a colliding event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_o <= 1'b0;
    else if (src_i)  stat_o <= 1'b1;
    else if (clr_i)  stat_o <= 1'b0;
  end
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          en_o,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  clr_o
);
  logic wr_ctrl, wr_mask, wr_raw;

  assign wr_ctrl = wr_en_i && (addr_i == AW'(REG_CTRL));
  assign wr_mask = wr_en_i && (addr_i == AW'(REG_MASK));
  assign wr_raw  = wr_en_i && (addr_i == AW'(REG_RAW));

  assign clr_o = wr_raw ? wr_data_i[N-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      mask_o <= '0;
    end else begin
      if (wr_ctrl) en_o   <= wr_data_i[EN_BIT];
      if (wr_mask) mask_o <= wr_data_i[N-1:0];
    end
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  src_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  localparam int unsigned PAD_W = DW - N;

  logic         en_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] clr;
  logic [N-1:0] raw_q;
  logic [N-1:0] masked;

  irq_ctl_regs #(.N(N), .DW(DW), .AW(AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .en_o      (en_q),
    .mask_o    (mask_q),
    .clr_o     (clr)
  );

  for (genvar i = 0; i < N; i++) begin : g_stat
    irq_stat_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_i[i]),
      .clr_i  (clr[i]),
      .stat_o (raw_q[i])
    );
  end

  assign masked = raw_q & mask_q;
  assign irq_o  = en_q && (|masked);

  always_comb begin
    unique case (addr_i)
      AW'(REG_CTRL):  rd_data_o = DW'(en_q) << EN_BIT;
      AW'(REG_MASK):  rd_data_o = {{PAD_W{1'b0}}, mask_q};
      AW'(REG_RAW):   rd_data_o = {{PAD_W{1'b0}}, raw_q};
      default:        rd_data_o = {{PAD_W{1'b0}}, masked};
    endcase
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  src_i,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic [N-1:0]  raw_q,
  input logic [N-1:0]  mask_q,
  input logic          en_q,
  input logic          irq_o
);
  AST_SRC_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((raw_q & $past(src_i)) == $past(src_i))); // R4

  AST_NO_SPONT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i || !wr_en_i) |=> ((raw_q & ~$past(raw_q) & ~$past(src_i)) == '0)); // R2

  AST_CLR_NEEDS_W1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == AW'(REG_RAW)) |=> ((~raw_q & $past(raw_q)) == '0)); // R3

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !irq_o); // R6

  AST_IRQ_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((raw_q & mask_q) != '0)); // R6

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == AW'(REG_MASK)) |=> $stable(mask_q)); // R9

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == AW'(REG_CTRL)) |=> $stable(en_q)); // R10
endmodule

bind irq_agg irq_agg_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_i     (src_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wr_data_i (wr_data_i),
  .raw_q     (raw_q),
  .mask_q    (mask_q),
  .en_q      (en_q),
  .irq_o     (irq_o)
);

// File: tb/irq_agg_bench.sv
`timescale 1ns/1ps
module irq_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic        m_en;
  logic [15:0] m_mask;
  logic [15:0] m_raw;

  always #5 clk = ~clk;

  irq_agg u_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(we),
    .addr_i(addr), .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 1'b0; m_mask <= '0; m_raw <= '0;
    end else begin
      if (we && addr == 2'd0) m_en <= wd[0];
      if (we && addr == 2'd1) m_mask <= wd[15:0];
      m_raw <= ((we && addr == 2'd2) ? (m_raw & ~wd[15:0]) : m_raw) | src;
    end
  end

  function automatic logic [31:0] model_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {31'b0, m_en};
      2'd1:    return {16'b0, m_mask};
      2'd2:    return {16'b0, m_raw};
      default: return {16'b0, m_raw & m_mask};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, then drive the next inputs
  task automatic cyc(input logic [15:0] s, input logic w, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    check("R6 irq", {31'b0, irq}, {31'b0, m_en && |(m_raw & m_mask)});
    case (addr)
      2'd0, 2'd1: check("R9 rd", rd, model_rd(addr));
      2'd2:       check("R7 rd", rd, model_rd(addr));
      default:    check("R8 rd", rd, model_rd(addr));
    endcase
    src = s; we = w; addr = a; wd = d;
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    cyc('0, 1'b0, a, '0);
    #1 check(tag, rd, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cyc('0, 1'b1, a, d);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 check("R1 irq", {31'b0, irq}, 32'd0);
    for (int a = 0; a < 4; a++) expect_rd(2'(a), 32'd0, "R1");

    // R2 single pulse latches, mask still 0 so no irq
    cyc(16'h0001, 1'b0, 2'd2, '0);
    expect_rd(2'd2, 32'h1, "R2");
    check("R6 masked-off", {31'b0, irq}, 32'd0);

    wr(2'd1, 32'h0000_0001);
    wr(2'd0, 32'h0000_0001);
    expect_rd(2'd3, 32'h1, "R8");
    check("R6 irq on", {31'b0, irq}, 32'd1);

    // R3 write 0 keeps, write 1 clears
    wr(2'd2, 32'h0000_0000);
    expect_rd(2'd2, 32'h1, "R3 w0");
    wr(2'd2, 32'h0000_0001);
    expect_rd(2'd2, 32'h0, "R3 w1");
    check("R6 irq off", {31'b0, irq}, 32'd0);

    // R4 collision: set wins
    cyc(16'h0020, 1'b0, 2'd2, '0);
    cyc(16'h0020, 1'b1, 2'd2, 32'h0000_0020);
    expect_rd(2'd2, 32'h20, "R4");
    wr(2'd2, 32'h20);
    expect_rd(2'd2, 32'h0, "R3 after R4");

    // R5 level source (bit 4 receive request)
    for (int i = 0; i < 3; i++) cyc(16'h0010, 1'b0, 2'd2, '0);
    cyc(16'h0010, 1'b1, 2'd2, 32'h10);
    cyc(16'h0010, 1'b0, 2'd2, '0);
    #1 check("R5 held", rd, 32'h10);
    cyc(16'h0000, 1'b0, 2'd2, '0);
    wr(2'd2, 32'h10);
    expect_rd(2'd2, 32'h0, "R5 released");

    // R9 unbacked bits read 0
    wr(2'd0, 32'hFFFF_FFFF);
    expect_rd(2'd0, 32'h1, "R9 ctrl");
    wr(2'd1, 32'hFFFF_FFFF);
    expect_rd(2'd1, 32'h0000_FFFF, "R9 mask");

    // R7 all sources, upper half zero
    cyc(16'hFFFF, 1'b0, 2'd2, '0);
    expect_rd(2'd2, 32'h0000_FFFF, "R7");

    // R10 write to masked-status word ignored
    wr(2'd3, 32'hFFFF_FFFF);
    expect_rd(2'd2, 32'h0000_FFFF, "R10 raw");
    expect_rd(2'd1, 32'h0000_FFFF, "R10 mask");
    expect_rd(2'd0, 32'h1, "R10 ctrl");

    // R6 global enable gates
    wr(2'd0, 32'h0);
    expect_rd(2'd3, 32'h0000_FFFF, "R8 en off");
    check("R6 en off", {31'b0, irq}, 32'd0);
    wr(2'd2, 32'hFFFF);

    // random mix, checked every cycle
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] s;
      s = (($urandom % 4) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      if (i % 200 < 60) s[3] = 1'b1;
      if (i % 300 < 40) s[4] = 1'b1;
      cyc(s, ($urandom % 3) == 0, 2'($urandom), $urandom);
    end
    cyc('0, 1'b0, 2'd2, '0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule